// File: doc/BRIEF.md
# Ethernet PAUSE Frame Transmitter

This block builds a complete MAC control PAUSE frame and streams it one byte per clock onto a byte-wide transmit path when a request arrives. A request can come from a control-word write or from an external pause line. A control-word write asks for either the programmed quantum or a quantum of zero. On the external pause line, any change of level is a request, and a companion level input picks between the programmed quantum and zero.

The frame carries the following, in order:

- the reserved multicast destination address;
- a programmable 48-bit source address;
- the MAC control type;
- the PAUSE opcode;
- the 16-bit quantum.

It is then zero-padded to the minimum frame length and closed by a CRC-32 frame check sequence. A single-cycle pulse on the last byte tells a statistics counter that one PAUSE frame went out. That pulse is the block's only side effect.

The block waits for a transmit-idle level from the surrounding MAC before it starts. A request that arrives while a frame is going out is held and served after that frame.

Top module: `eth_pause_tx`

## Requirements
- R1: A `ctl_wr` cycle with `ctl_wdata` bit 11 set and bit 12 clear sends one frame whose quantum equals the current quantum register.
- R2: A `ctl_wr` cycle with `ctl_wdata` bit 12 set sends one frame with quantum 0x0000, whether or not bit 11 is also set.
- R3: A level change (either direction) of `ext_pause`, after synchronisation, sends one frame. The quantum is the register value when the synchronised `ext_pause_zero` is low, and 0x0000 when it is high.
- R4: The quantum register holds 0xFFFF after reset, and a `quanta_wr` cycle loads it from `quanta_wdata`.
- R5: The bytes are sent in this order:
  - bytes 0..5: 01 80 C2 00 00 01;
  - bytes 6..11: `src_addr[47:40]` first, down to `src_addr[7:0]`;
  - bytes 12..13: 88 08;
  - bytes 14..15: 00 01;
  - bytes 16..17: the quantum, high byte first;
  - bytes 18..59: 0x00.
- R6: Bytes 60..63 are the frame check sequence, least significant byte first. It is a CRC-32 over bytes 0..59 with polynomial 0x04C11DB7, all-ones start value, reflected input and output, and a final inversion. `tx_valid` stays high for exactly 64 consecutive cycles. `tx_last` is high only on byte 63, and `tx_valid` is low in the cycle after it.
- R7: `stat_inc` pulses exactly once per frame, in the cycle of byte 63, and at no other time.
- R8: A frame starts only after a cycle in which `tx_idle` is high. A request that arrives while a frame is being sent is kept and produces a further frame after the current one ends.
- R9: A `ctl_wr` cycle with neither bit 11 nor bit 12 set sends no frame.
- R10: After reset, `tx_valid`, `tx_last` and `stat_inc` are low until a request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; bit 11 = send with register quantum, bit 12 = send with zero quantum |
| quanta_wr | input | 1 | Quantum register write strobe |
| quanta_wdata | input | 16 | New quantum register value |
| src_addr | input | 48 | Source MAC address placed in the frame |
| ext_pause | input | 1 | Asynchronous pause request line, toggle-triggered |
| ext_pause_zero | input | 1 | Asynchronous zero-quantum select for `ext_pause` requests |
| tx_idle | input | 1 | High when the transmit path may start a frame |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Marks the final byte of the frame |
| stat_inc | output | 1 | One-cycle pulse per transmitted PAUSE frame |

## Verification
A corrupted running CRC or frame byte counter shows at the ports within the same frame. A bad CRC appears only in bytes 60..63. A bad counter shifts the header, lengthens the burst or misplaces `tx_last` and `stat_inc` within at most 64 cycles. A wrong pending flag or quantum select is seen within a few cycles of the request: a frame is missing or extra, or bytes 16..17 carry the wrong quantum. Each frame is therefore compared byte for byte against a model built independently in the bench, including a CRC computed in the non-reflected form on bit-reversed data.

// File: rtl/eth_pause_pkg.sv
package eth_pause_pkg;

  localparam logic [47:0] PAUSE_DA   = 48'h0180_C200_0001;
  localparam logic [15:0] MAC_CTL_TY = 16'h8808;
  localparam logic [15:0] PAUSE_OPC  = 16'h0001;
  localparam int          HDR_LEN    = 18;
  localparam int          FCS_LEN    = 4;
  localparam int          CTL_BIT_REG  = 11;
  localparam int          CTL_BIT_ZERO = 12;

  typedef enum logic {QSEL_REG = 1'b0, QSEL_ZERO = 1'b1} qsel_e;

  // one byte through the reflected CRC-32 (LSB first)
  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB8_8320;
    end
    return r;
  endfunction

  // header byte at position i; zero beyond the header (padding)
  function automatic logic [7:0] hdr_byte(int i, logic [47:0] sa, logic [15:0] q);
    logic [7:0] b;
    if (i < 6)        b = PAUSE_DA[8*(5-i) +: 8];
    else if (i < 12)  b = sa[8*(11-i) +: 8];
    else if (i == 12) b = MAC_CTL_TY[15:8];
    else if (i == 13) b = MAC_CTL_TY[7:0];
    else if (i == 14) b = PAUSE_OPC[15:8];
    else if (i == 15) b = PAUSE_OPC[7:0];
    else if (i == 16) b = q[15:8];
    else if (i == 17) b = q[7:0];
    else              b = 8'h00;
    return b;
  endfunction

endpackage

// File: rtl/eth_pause_req.sv
module eth_pause_req
  import eth_pause_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_go_reg,
  input  logic  ctl_go_zero,
  input  logic  ext_pause,
  input  logic  ext_pause_zero,
  input  logic  take,
  output logic  req_fire,
  output logic  pending,
  output qsel_e qsel
);

  logic [SYNC_STAGES-1:0] p_sync, z_sync;
  logic                   p_prev;
  logic                   toggle, ctl_req;
  qsel_e                  new_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_sync <= '0;
      z_sync <= '0;
      p_prev <= 1'b0;
    end else begin
      p_sync <= {p_sync[SYNC_STAGES-2:0], ext_pause};
      z_sync <= {z_sync[SYNC_STAGES-2:0], ext_pause_zero};
      p_prev <= p_sync[SYNC_STAGES-1];
    end
  end

  assign toggle   = p_sync[SYNC_STAGES-1] ^ p_prev;
  assign ctl_req  = ctl_go_reg | ctl_go_zero;
  assign req_fire = ctl_req | toggle;

  always_comb begin
    if (ctl_req) new_sel = ctl_go_zero ? QSEL_ZERO : QSEL_REG;
    else         new_sel = z_sync[SYNC_STAGES-1] ? QSEL_ZERO : QSEL_REG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      qsel    <= QSEL_REG;
    end else if (req_fire) begin
      pending <= 1'b1;
      qsel    <= new_sel;
    end else if (take) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/eth_pause_fmt.sv
module eth_pause_fmt
  import eth_pause_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int IDXW    = 6
) (
  input  logic [IDXW-1:0] idx,
  input  logic [47:0]     sa,
  input  logic [15:0]     q,
  input  logic [31:0]     crc,
  output logic [7:0]      byte_o
);

  logic [IDXW-1:0] off;
  logic [31:0]     fcs;
  logic            unused_off;

  assign off        = idx - IDXW'(MIN_LEN);
  assign fcs        = ~crc;
  assign unused_off = ^off[IDXW-1:2];

  always_comb begin
    if (int'(idx) < MIN_LEN) byte_o = hdr_byte(int'(idx), sa, q);
    else                     byte_o = fcs[{off[1:0], 3'b000} +: 8];
  end

endmodule

// File: rtl/eth_pause_tx.sv
module eth_pause_tx
  import eth_pause_pkg::*;
#(
  parameter int          MIN_LEN     = 60,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] QUANTA_RST  = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic        quanta_wr,
  input  logic [15:0] quanta_wdata,
  input  logic [47:0] src_addr,
  input  logic        ext_pause,
  input  logic        ext_pause_zero,
  input  logic        tx_idle,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        stat_inc
);

  localparam int FRAME_LEN = MIN_LEN + FCS_LEN;
  localparam int IDXW      = $clog2(FRAME_LEN);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_LEN - 1);

  logic [15:0]     quanta_q, q_lat;
  logic [47:0]     sa_lat;
  logic [31:0]     crc_q;
  logic [IDXW-1:0] idx;
  logic            busy;
  logic            pending, req_fire, frame_start;
  qsel_e           qsel;
  logic [7:0]      cur_byte;
  logic            unused_ctl;

  assign unused_ctl = ^{ctl_wdata[31:CTL_BIT_ZERO+1], ctl_wdata[CTL_BIT_REG-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)         quanta_q <= QUANTA_RST;
    else if (quanta_wr) quanta_q <= quanta_wdata;
  end

  eth_pause_req #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_go_reg     (ctl_wr & ctl_wdata[CTL_BIT_REG]),
    .ctl_go_zero    (ctl_wr & ctl_wdata[CTL_BIT_ZERO]),
    .ext_pause      (ext_pause),
    .ext_pause_zero (ext_pause_zero),
    .take           (frame_start),
    .req_fire       (req_fire),
    .pending        (pending),
    .qsel           (qsel)
  );

  assign frame_start = pending & tx_idle & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      crc_q  <= '1;
      q_lat  <= '0;
      sa_lat <= '0;
    end else if (frame_start) begin
      busy   <= 1'b1;
      idx    <= '0;
      crc_q  <= '1;
      q_lat  <= (qsel == QSEL_ZERO) ? 16'h0000 : quanta_q;
      sa_lat <= src_addr;
    end else if (busy) begin
      if (int'(idx) < MIN_LEN) crc_q <= crc32_step(crc_q, cur_byte);
      if (idx == LAST_IDX) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  eth_pause_fmt #(.MIN_LEN(MIN_LEN), .IDXW(IDXW)) u_fmt (
    .idx    (idx),
    .sa     (sa_lat),
    .q      (q_lat),
    .crc    (crc_q),
    .byte_o (cur_byte)
  );

  assign tx_valid = busy;
  assign tx_data  = busy ? cur_byte : 8'h00;
  assign tx_last  = busy && (idx == LAST_IDX);
  assign stat_inc = tx_last;

endmodule

// File: rtl/eth_pause_chk.sv
module eth_pause_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       stat_inc,
  input logic       tx_idle,
  input logic       req_fire,
  input logic       pending
);

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) tx_last |-> tx_valid); // R6
  AST_BURST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n) tx_valid && !tx_last |=> tx_valid); // R6
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) tx_last |=> !tx_valid); // R6
  AST_FIRST_BYTE_DA: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_valid) |-> tx_data == 8'h01); // R5
  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_valid) |-> $past(tx_idle)); // R8
  AST_STAT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n) stat_inc |-> $past(tx_valid)); // R7
  AST_FIRE_HELD: assert property (@(posedge clk) disable iff (!rst_n) req_fire |=> pending); // R8

endmodule

bind eth_pause_tx eth_pause_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_last  (tx_last),
  .stat_inc (stat_inc),
  .tx_idle  (tx_idle),
  .req_fire (req_fire),
  .pending  (pending)
);

// File: tb/test_eth_pause_tx.sv
`timescale 1ns/1ps
module test_eth_pause_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        quanta_wr = 1'b0;
  logic [15:0] quanta_wdata = '0;
  logic [47:0] src_addr = 48'h0000_0000_0000;
  logic        ext_pause = 1'b0;
  logic        ext_pause_zero = 1'b0;
  logic        tx_idle = 1'b1;
  logic        tx_valid, tx_last, stat_inc;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0]  expf [64];
  logic [15:0] qreg_model = 16'hFFFF;

  always #4 clk = ~clk;

  eth_pause_tx i_eth_pause_tx (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .quanta_wr(quanta_wr), .quanta_wdata(quanta_wdata), .src_addr(src_addr),
    .ext_pause(ext_pause), .ext_pause_zero(ext_pause_zero), .tx_idle(tx_idle),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .stat_inc(stat_inc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // non-reflected CRC on bit-reversed bytes, then reversed and inverted
  function automatic logic [31:0] model_fcs();
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] r;
    for (int n = 0; n < 60; n++) begin
      c = c ^ {rev8(expf[n]), 24'h0};
      for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
    end
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    return ~r;
  endfunction

  task automatic build(input logic [47:0] sa, input logic [15:0] q);
    logic [31:0] f;
    logic [7:0] hdr [18];
    hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01,
            sa[47:40], sa[39:32], sa[31:24], sa[23:16], sa[15:8], sa[7:0],
            8'h88, 8'h08, 8'h00, 8'h01, q[15:8], q[7:0]};
    for (int n = 0; n < 60; n++) expf[n] = (n < 18) ? hdr[n] : 8'h00;
    f = model_fcs();
    for (int n = 0; n < 4; n++) expf[60+n] = f[8*n +: 8];
  endtask

  task automatic expect_frame(input logic [47:0] sa, input logic [15:0] q, input string req);
    int w = 0;
    int bad = 0;
    build(sa, q);
    while (!tx_valid && w < 300) begin @(negedge clk); w++; end
    check(tx_valid, req, "frame start", 32'(tx_valid), 1);
    if (!tx_valid) return;
    for (int n = 0; n < 64; n++) begin
      if (tx_data !== expf[n]) begin
        bad++;
        check(0, (n < 60) ? "R5" : "R6", $sformatf("byte %0d", n), 32'(tx_data), 32'(expf[n]));
      end
      if (tx_valid !== 1'b1 || tx_last !== (n == 63)) begin
        bad++;
        check(0, "R6", $sformatf("valid/last at %0d", n), {tx_valid, tx_last}, {1'b1, n == 63});
      end
      if (stat_inc !== (n == 63)) begin
        bad++;
        check(0, "R7", $sformatf("stat at %0d", n), 32'(stat_inc), 32'(n == 63));
      end
      @(negedge clk);
    end
    check(bad == 0, req, "frame content", bad, 0);
    check(tx_valid == 1'b0, "R6", "gap after last", 32'(tx_valid), 0);
  endtask

  task automatic expect_none(input int cyc, input string req);
    int seen = 0;
    for (int n = 0; n < cyc; n++) begin
      @(negedge clk);
      if (tx_valid || stat_inc) seen++;
    end
    check(seen == 0, req, "no frame", seen, 0);
  endtask

  task automatic ctl_write(input logic [31:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic q_write(input logic [15:0] d);
    @(negedge clk); quanta_wr = 1'b1; quanta_wdata = d;
    @(negedge clk); quanta_wr = 1'b0;
    qreg_model = d;
  endtask

  task automatic ext_toggle(input bit zero);
    @(negedge clk); ext_pause_zero = zero;
    repeat (4) @(negedge clk);
    ext_pause = ~ext_pause;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check(!tx_valid && !tx_last && !stat_inc, "R10", "outputs after reset",
          {tx_valid, tx_last, stat_inc}, 0);
    expect_none(20, "R10");

    src_addr = 48'h0011_2233_4455;
    ctl_write(32'h0000_0800);
    expect_frame(src_addr, 16'hFFFF, "R4");          // R4 reset value via R1
    q_write(16'h1234);
    ctl_write(32'h0000_0800);
    expect_frame(src_addr, 16'h1234, "R1");
    ctl_write(32'h0000_1000);
    expect_frame(src_addr, 16'h0000, "R2");
    ctl_write(32'h0000_1800);
    expect_frame(src_addr, 16'h0000, "R2");          // both bits: zero wins
    ctl_write(32'hFFFF_E7FF);
    expect_none(60, "R9");

    ext_toggle(1'b0);
    expect_frame(src_addr, 16'h1234, "R3");
    ext_toggle(1'b1);
    expect_frame(src_addr, 16'h0000, "R3");

    // R8 idle gating
    tx_idle = 1'b0;
    ctl_write(32'h0000_0800);
    expect_none(30, "R8");
    tx_idle = 1'b1;
    expect_frame(src_addr, 16'h1234, "R8");

    // R8 request during a frame is kept
    ctl_write(32'h0000_0800);
    fork
      expect_frame(src_addr, 16'h1234, "R8");
      begin repeat (20) @(negedge clk); ctl_write(32'h0000_1000); end
    join
    expect_frame(src_addr, 16'h0000, "R8");
    expect_none(40, "R8");

    // constrained random
    for (int it = 0; it < 24; it++) begin
      int kind = $urandom_range(0, 3);
      src_addr = {$urandom(), $urandom()} & 48'hFEFF_FFFF_FFFF;
      if ($urandom_range(0, 1)) q_write(16'($urandom()));
      case (kind)
        0: begin ctl_write(32'h0000_0800); expect_frame(src_addr, qreg_model, "R1"); end
        1: begin ctl_write(32'h0000_1000 | ($urandom() & 32'h0000_0800)); expect_frame(src_addr, 16'h0000, "R2"); end
        2: begin ext_toggle(1'b0); expect_frame(src_addr, qreg_model, "R3"); end
        default: begin ext_toggle(1'b1); expect_frame(src_addr, 16'h0000, "R3"); end
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule